// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block sits after an external dual-modulus prescaler and turns it into a programmable divider with ratio N·P + A. It is clocked by the prescaler output. One prescaler output period is one count of this block. A 10-bit main count N and a 6-bit swallow count A arrive as parallel inputs. They are loaded only at the start of each count cycle, so they may change at any time without corrupting the cycle that is running.

A count cycle is N prescaler periods long. For the first A of those periods the control output is low, and the prescaler divides by P+1. For the remaining N − A periods the control output is high, and the prescaler divides by P. The total number of prescaler input pulses per cycle is therefore A·(P+1) + (N−A)·P = N·P + A. A terminal pulse marks the last period of every cycle and is the divided output to the phase detector.

Top module: `swallow_div_ctl`

## Requirements
- R1: While the synchronous active-low reset is held, both counters load from the program inputs. With a nonzero A and an N other than 1, `mod_ctl` is low and `tc_pulse` is low.
- R2: For N in 1..1023, every count cycle lasts exactly N clock periods. The cycle boundary is the clock edge that ends a period in which `tc_pulse` was high.
- R3: Within a cycle, `mod_ctl` is low for exactly the first A periods and then high for the remaining N − A periods. It never drops back low before the cycle ends.
- R4: With A = 0, `mod_ctl` is high for the whole cycle, starting with the cycle's first period.
- R5: With A = N, `mod_ctl` is low for the whole cycle.
- R6: `n_prog` and `a_prog` take effect only at a reload edge (the edge ending a `tc_pulse` period, or a reset edge). Changes made during a cycle alter nothing in that cycle.
- R7: `tc_pulse` is high during exactly one period per cycle, the last one. With N = 1 it is therefore high continuously.
- R8: N = 0 is treated as 1024, so the cycle lasts 1024 periods.
- R9: With a prescaler that gives P+1 input pulses per period while `mod_ctl` is low and P while it is high, each cycle consumes N·P + A input pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, one rising edge per count |
| rst_n | input | 1 | Synchronous reset, active low |
| n_prog | input | 10 | Main count N (0 means 1024) |
| a_prog | input | 6 | Swallow count A, must not exceed N |
| mod_ctl | output | 1 | 0: prescaler divides by P+1, 1: by P |
| tc_pulse | output | 1 | High during the last period of each cycle |

## Verification
The reload of both counters and the modulus switch can fall on the same edge. With A = 0, `mod_ctl` rises on the very edge where the counters reload. With A = N, it stays low across that boundary. With N = 1, reload happens on every edge. The bench provokes these cases with directed settings. It also changes the program values at random points within random cycles. Each cycle's period count, low-period count, low-before-high ordering and modelled prescaler pulse total are judged against the N and A present at the preceding reload edge.

// File: rtl/sc_pkg.sv
// Shared widths for the swallow counter controller.
// Assumes the main count fits 10 bits and the swallow count fits 6 bits.
package sc_pkg;
    localparam int unsigned N_W_DEF = 10;
    localparam int unsigned A_W_DEF = 6;
endpackage

// File: rtl/sc_cycle_cnt.sv
// Main cycle counter: counts prescaler periods down and flags the last
// period of each cycle. Reloads from load_val on reset or at its own terminal.
// Assumes load_val == 0 means 2**W periods.
module sc_cycle_cnt #(
    parameter int unsigned W = sc_pkg::N_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_val,
    output logic         terminal
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;

    assign terminal = (cnt == ONE);

    // Reload at reset or cycle end, else step down one period.
    always_ff @(posedge clk) begin
        if (!rst_n || terminal) cnt <= load_val;
        else                    cnt <= cnt - ONE;
    end

    // R2: between reloads the count moves down by exactly one each period
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !terminal |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/sc_swallow_cnt.sv
// Swallow counter: counts the first load_val periods of a cycle, then holds
// at zero with done high until the next reload.
// Assumes reload is the main counter's terminal flag.
module sc_swallow_cnt #(
    parameter int unsigned W = sc_pkg::A_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    output logic         done
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt;

    assign done = (cnt == ZERO);

    // Reload at reset or cycle end, else count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) cnt <= load_val;
        else if (!done)       cnt <= cnt - ONE;
    end

    // R3: once the swallow phase ends it stays ended until a reload
    assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reload) |=> done);
endmodule

// File: rtl/swallow_div_ctl.sv
// Dual-modulus swallow counter controller. It is clocked by the prescaler
// output. mod_ctl is low while the swallow count runs (prescaler /P+1) and
// high afterwards (/P). tc_pulse marks the last period of each N-period cycle.
// Assumes a_prog <= n_prog (n_prog == 0 meaning 1024).
module swallow_div_ctl #(
    parameter int unsigned N_W = sc_pkg::N_W_DEF,
    parameter int unsigned A_W = sc_pkg::A_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_prog,
    input  logic [A_W-1:0] a_prog,
    output logic           mod_ctl,
    output logic           tc_pulse
);
    localparam logic [N_W-1:0] N_ONE  = {{(N_W-1){1'b0}}, 1'b1};
    localparam logic [A_W-1:0] A_ZERO = '0;

    logic cyc_end;
    logic swl_done;

    sc_cycle_cnt #(.W(N_W)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (n_prog),
        .terminal (cyc_end)
    );

    sc_swallow_cnt #(.W(A_W)) u_swallow (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (cyc_end),
        .load_val (a_prog),
        .done     (swl_done)
    );

    // Drive the outputs straight from the counter flags.
    always_comb begin
        mod_ctl  = swl_done;
        tc_pulse = cyc_end;
    end

    // R3/R4: the first period of a new cycle is low exactly when the loaded A is nonzero
    assert_cycle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> (mod_ctl == ($past(a_prog) == A_ZERO)));

    // R7: the terminal pulse lasts one period unless the next cycle is one period long
    assert_tc_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && n_prog != N_ONE) |=> !tc_pulse);

    // R3: the control output falls only at a cycle boundary
    assert_ctl_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_ctl && !tc_pulse) |=> mod_ctl);
endmodule

// File: tb/tb_swallow_div_ctl.sv
module tb_swallow_div_ctl;
    localparam int P = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] n_prog = 10'd5;
    logic [5:0] a_prog = 6'd2;
    logic       mod_ctl;
    logic       tc_pulse;

    int total = 0;
    int bad = 0;
    int cycles_done = 0;
    bit finished = 0;

    swallow_div_ctl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .n_prog   (n_prog),
        .a_prog   (a_prog),
        .mod_ctl  (mod_ctl),
        .tc_pulse (tc_pulse)
    );

    always #2.5 clk = ~clk;

    function automatic int eff_n(input int n);
        return (n == 0) ? 1024 : n;
    endfunction

    function automatic int exp_pulses(input int n, input int a);
        return eff_n(n) * P + a;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Cycle monitor: samples at the falling edge, models the prescaler.
    int  cur_n, cur_a, len, lows, pulses;
    bit  seen_high, order_ok;
    always @(negedge clk) begin
        if (!rst_n) begin
            cur_n = n_prog; cur_a = a_prog;
            len = 0; lows = 0; pulses = 0; seen_high = 0; order_ok = 1;
        end else begin
            len++;
            if (!mod_ctl) begin
                lows++; pulses += P + 1;
                if (seen_high) order_ok = 0;
            end else begin
                seen_high = 1; pulses += P;
            end
            if (tc_pulse) begin
                chk(len == eff_n(cur_n), (cur_n == 0) ? "R8" : "R2", len, eff_n(cur_n));
                chk(lows == cur_a, (cur_a == 0) ? "R4" : (cur_a == cur_n) ? "R5" : "R3",
                    lows, cur_a);
                chk(order_ok, "R3", order_ok, 1);
                chk(pulses == exp_pulses(cur_n, cur_a), "R9", pulses,
                    exp_pulses(cur_n, cur_a));
                cur_n = n_prog; cur_a = a_prog;
                len = 0; lows = 0; pulses = 0; seen_high = 0; order_ok = 1;
                cycles_done++;
            end else if (len > eff_n(cur_n)) begin
                chk(0, "R7", len, eff_n(cur_n));
                len = 0;
            end
        end
    end

    task automatic set_prog(input int n, input int a);
        @(posedge clk); #1;
        n_prog = n[9:0]; a_prog = a[5:0];
    endtask

    task automatic wait_cycles(input int k);
        int target = cycles_done + k;
        while (cycles_done < target) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles_done, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mod_ctl == 1'b0, "R1", mod_ctl, 0);
        chk(tc_pulse == 1'b0, "R1", tc_pulse, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        wait_cycles(3);                       // N=5, A=2
        set_prog(9, 0);  wait_cycles(3);      // A=0, control high from reload edge
        set_prog(7, 7);  wait_cycles(3);      // A=N, low all cycle
        set_prog(1, 0);  wait_cycles(4);      // N=1, reload every edge
        set_prog(1, 1);  wait_cycles(4);
        set_prog(0, 63); wait_cycles(2);      // N=0 means 1024
        set_prog(63, 63); wait_cycles(2);
        for (int i = 0; i < 40; i++) begin    // R6: mid-cycle changes
            int n1 = 1 + ($urandom % 300);
            int a1 = $urandom % ((n1 < 63 ? n1 : 63) + 1);
            int n2 = 1 + ($urandom % 300);
            int a2 = $urandom % ((n2 < 63 ? n2 : 63) + 1);
            set_prog(n1, a1);
            repeat ($urandom % 40) @(posedge clk);
            set_prog(n2, a2);
            wait_cycles(1);
        end
        wait_cycles(1);
        chk(cycles_done >= 62, "R6", cycles_done, 62);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule